// File: doc/BRIEF.md
# Dual-Channel Microstep Register with Decay Detection

This block is the register file behind a two-phase microstepping current controller. A processor writes it over an 8-bit data port qualified by a write strobe, an active-low chip select and two address bits. Each of the two channels holds a 7-bit current magnitude code, a direction (sign) bit and a 3-bit decay threshold. The magnitude codes and sign bits leave the block as digital outputs that feed a converter and a winding driver.

Every magnitude write also re-evaluates an active-low fast-decay output for that channel. The output goes low when the new magnitude is below the value it replaces and, at the same time, its upper three bits are below the channel's programmed threshold. Otherwise the output goes high. The strobe and chip select are asynchronous to the system clock. They pass through a two-flop synchronizer, and a write is taken on the synchronized rising edge of the strobe.

Top module: `ustep_regfile`

## Requirements
- R1: A synchronous active-high reset clears both magnitude codes, both sign outputs, both decay outputs and both thresholds to zero.
- R2: While chip select is high, strobe edges change no output and no threshold.
- R3: A write happens once per rising edge of the strobe. Data changed while the strobe stays high is not loaded.
- R4: Address bit 0 selects the channel (0 = channel 0, 1 = channel 1). Address bit 1 selects the target (0 = magnitude/sign, 1 = decay threshold).
- R5: On a magnitude write, data bit 7 drives the channel's sign output unchanged and data bits 6..0 load the channel's magnitude code.
- R6: On a threshold write, data bits 6..4 load the channel's 3-bit threshold. Magnitude, sign and decay outputs are left unchanged.
- R7: On a magnitude write, the decay output goes low when the new 7-bit code is strictly less than the stored code and the new bits 6..4 are strictly less than the threshold.
- R8: A new code equal to the stored code, or new bits 6..4 equal to the threshold, drives the decay output high. With threshold 0 the decay output never goes low.
- R9: The decay output holds its value between magnitude writes to its own channel.
- R10: The comparison uses the code stored before the write, and the new code replaces it on the same edge.
- R11: A write to one channel leaves every output and the threshold of the other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_strobe_i | input | 1 | Write strobe, asynchronous, captured on its rising edge |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| addr_i | input | 2 | Bit 0 selects the channel, bit 1 selects the target |
| data_i | input | 8 | Write data |
| mag_o | output | 14 | Magnitude codes, channel 0 in bits 6..0, channel 1 in bits 13..7 |
| sign_o | output | 2 | Sign outputs, one bit per channel |
| decay_n_o | output | 2 | Fast-decay outputs, active low, one bit per channel |

## Verification
The bench aims at the strict comparisons. It tests a new code equal to the old one and a new top field equal to the threshold. A design that used less-or-equal would pull the decay output low in those cases. It checks that threshold writes leave the decay output alone, because a design that re-evaluated on any write would flip it. It holds the strobe high while the data changes, to catch edge detection that loads data on the level of the strobe. It also writes the two channels in turn, so a design that compared against the other channel's code, or against the code after the write, produces a wrong decay value.

// File: rtl/ustep_pkg.sv
package ustep_pkg;

    localparam int MAG_W   = 7;
    localparam int LVL_W   = 3;
    localparam int DATA_W  = MAG_W + 1;
    localparam int NUM_CH  = 2;
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int ADDR_W  = CH_W + 1;
    localparam int SIGN_BIT = DATA_W - 1;
    localparam int TOP_LSB = MAG_W - LVL_W;

    typedef enum logic {
        TGT_MAG = 1'b0,
        TGT_LVL = 1'b1
    } target_e;

    typedef struct packed {
        logic              valid;
        logic [CH_W-1:0]   ch;
        target_e           tgt;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic decay_n_calc(
        input logic [MAG_W-1:0] new_mag,
        input logic [MAG_W-1:0] old_mag,
        input logic [LVL_W-1:0] lvl
    );
        logic falling;
        logic below;
        falling = (new_mag < old_mag);
        below   = (new_mag[MAG_W-1:TOP_LSB] < lvl);
        return !(falling && below);
    endfunction

endpackage

// File: rtl/ustep_sync.sv
module ustep_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    input  logic [WIDTH-1:0] rst_val_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[s] <= rst_val_i;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ustep_wrdet.sv
module ustep_wrdet
    import ustep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_s_i,
    input  logic              cs_n_s_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output wr_req_t           req_o
);
    logic strobe_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_prev_q <= 1'b0;
        end else begin
            strobe_prev_q <= strobe_s_i;
        end
    end

    always_comb begin
        req_o.valid = strobe_s_i && !strobe_prev_q && !cs_n_s_i;
        req_o.ch    = addr_i[CH_W-1:0];
        req_o.tgt   = target_e'(addr_i[ADDR_W-1]);
        req_o.data  = data_i;
    end

    // R3
    single_write_chk: assert property (@(posedge clk) disable iff (rst)
        req_o.valid |=> !req_o.valid);

    // R2
    cs_gate_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_s_i |-> !req_o.valid);
endmodule

// File: rtl/ustep_chan.sv
module ustep_chan
    import ustep_pkg::*;
#(
    parameter int CH_ID = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          req_i,
    output logic [MAG_W-1:0] mag_o,
    output logic             sign_o,
    output logic             decay_n_o
);
    logic             hit;
    logic             mag_we;
    logic             lvl_we;
    logic [MAG_W-1:0] new_mag;
    logic [LVL_W-1:0] lvl_q;

    assign hit     = req_i.valid && (req_i.ch == CH_W'(CH_ID));
    assign mag_we  = hit && (req_i.tgt == TGT_MAG);
    assign lvl_we  = hit && (req_i.tgt == TGT_LVL);
    assign new_mag = req_i.data[MAG_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mag_o     <= '0;
            sign_o    <= 1'b0;
            decay_n_o <= 1'b0;
        end else if (mag_we) begin
            mag_o     <= new_mag;
            sign_o    <= req_i.data[SIGN_BIT];
            decay_n_o <= decay_n_calc(new_mag, mag_o, lvl_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
        end else if (lvl_we) begin
            lvl_q <= req_i.data[MAG_W-1:TOP_LSB];
        end
    end

    // R9
    decay_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mag_we |=> $stable(decay_n_o));

    // R6
    lvl_side_chk: assert property (@(posedge clk) disable iff (rst)
        lvl_we |=> ($stable(mag_o) && $stable(sign_o)));

    // R5
    mag_load_chk: assert property (@(posedge clk) disable iff (rst)
        mag_we |=> (mag_o == $past(new_mag)) && (sign_o == $past(req_i.data[SIGN_BIT])));

    // R8
    rise_slow_chk: assert property (@(posedge clk) disable iff (rst)
        (mag_we && (new_mag >= mag_o)) |=> decay_n_o);

    // R7
    fast_chk: assert property (@(posedge clk) disable iff (rst)
        (mag_we && (new_mag < mag_o) && (new_mag[MAG_W-1:TOP_LSB] < lvl_q)) |=> !decay_n_o);
endmodule

// File: rtl/ustep_regfile.sv
module ustep_regfile
    import ustep_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_strobe_i,
    input  logic                    cs_n_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       data_i,
    output logic [NUM_CH*MAG_W-1:0] mag_o,
    output logic [NUM_CH-1:0]       sign_o,
    output logic [NUM_CH-1:0]       decay_n_o
);
    logic [1:0] ctl_s;
    wr_req_t    req;

    ustep_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .async_i   ({cs_n_i, wr_strobe_i}),
        .rst_val_i (2'b10),
        .sync_o    (ctl_s)
    );

    ustep_wrdet u_wrdet (
        .clk        (clk),
        .rst        (rst),
        .strobe_s_i (ctl_s[0]),
        .cs_n_s_i   (ctl_s[1]),
        .addr_i     (addr_i),
        .data_i     (data_i),
        .req_o      (req)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            ustep_chan #(.CH_ID(c)) u_chan (
                .clk       (clk),
                .rst       (rst),
                .req_i     (req),
                .mag_o     (mag_o[c*MAG_W +: MAG_W]),
                .sign_o    (sign_o[c]),
                .decay_n_o (decay_n_o[c])
            );

            // R11
            other_ch_chk: assert property (@(posedge clk) disable iff (rst)
                (req.valid && (req.ch != CH_W'(c))) |=>
                    ($stable(mag_o[c*MAG_W +: MAG_W]) && $stable(sign_o[c]) && $stable(decay_n_o[c])));
        end
    endgenerate
endmodule

// File: tb/ustep_regfile_tb.sv
module ustep_regfile_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_strobe = 1'b0;
    logic       cs_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] data = '0;
    logic [13:0] mag;
    logic [1:0]  sign;
    logic [1:0]  decay_n;

    int n_chk = 0;
    int n_fail = 0;

    logic [6:0] m_mag [2];
    logic       m_sign [2];
    logic [2:0] m_lvl [2];
    logic       m_dn [2];

    always #4 clk = ~clk;

    ustep_regfile dut_i (
        .clk(clk), .rst(rst), .wr_strobe_i(wr_strobe), .cs_n_i(cs_n),
        .addr_i(addr), .data_i(data), .mag_o(mag), .sign_o(sign), .decay_n_o(decay_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < 2; c++) begin
            chk(req, int'(mag[c*7 +: 7]), int'(m_mag[c]));
            chk(req, int'(sign[c]), int'(m_sign[c]));
            chk(req, int'(decay_n[c]), int'(m_dn[c]));
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_mag[c] = '0; m_sign[c] = 1'b0; m_lvl[c] = '0; m_dn[c] = 1'b0;
        end
    endtask

    // R4 address: bit0 channel, bit1 target (0 magnitude, 1 threshold)
    task automatic bus_write(input int ch, input bit lvl, input logic [7:0] d, input bit sel);
        @(negedge clk);
        addr = {lvl, ch[0]};
        data = d;
        cs_n = !sel;
        repeat (3) @(negedge clk);
        wr_strobe = 1'b1;
        repeat (6) @(negedge clk);
        wr_strobe = 1'b0;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        if (sel) begin
            if (lvl) begin
                m_lvl[ch] = d[6:4];
            end else begin
                m_dn[ch]   = !((d[6:0] < m_mag[ch]) && (d[6:4] < m_lvl[ch]));
                m_mag[ch]  = d[6:0];
                m_sign[ch] = d[7];
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check_all("R1");
    endtask

    task automatic t_mag_sign();
        bus_write(0, 0, 8'hC5, 1);
        check_all("R5");
        bus_write(1, 0, 8'h3A, 1);
        check_all("R4");
        // R8: threshold 0 never gives fast decay
        bus_write(0, 0, 8'h01, 1);
        chk("R8", int'(decay_n[0]), 1);
    endtask

    task automatic t_decay();
        bus_write(0, 1, 8'h50, 1);          // threshold 5
        check_all("R6");
        bus_write(0, 0, 8'h7F, 1);          // rise -> high
        check_all("R8");
        bus_write(0, 0, 8'h30, 1);          // 48<127, 3<5 -> low
        check_all("R7");
        chk("R7", int'(decay_n[0]), 0);
        bus_write(0, 0, 8'h30, 1);          // equal -> high
        chk("R8", int'(decay_n[0]), 1);
        bus_write(0, 0, 8'h5F, 1);          // rise
        bus_write(0, 0, 8'h50, 1);          // top 5 == thr 5 -> high
        chk("R8", int'(decay_n[0]), 1);
        bus_write(0, 0, 8'h4F, 1);          // 79<80, top 4<5 -> low
        chk("R10", int'(decay_n[0]), 0);
        bus_write(0, 0, 8'h4E, 1);          // against 79 stored -> low
        check_all("R10");
    endtask

    task automatic t_level_no_effect();
        // decay_n[0] low now; threshold write must not touch it
        bus_write(0, 1, 8'h8F, 1);          // threshold 0, other bits ignored
        check_all("R9");
        chk("R9", int'(decay_n[0]), 0);
        bus_write(0, 0, 8'h10, 1);          // falls but thr 0 -> high
        check_all("R6");
    endtask

    task automatic t_cs_high();
        bus_write(1, 0, 8'hFF, 0);
        bus_write(1, 1, 8'h70, 0);
        check_all("R2");
        bus_write(1, 0, 8'h00, 1);          // thr still 0 -> high
        check_all("R2");
    endtask

    task automatic t_held_strobe();
        @(negedge clk);
        addr = 2'b00; data = 8'h22; cs_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_strobe = 1'b1;
        repeat (6) @(negedge clk);
        data = 8'h99;
        repeat (6) @(negedge clk);
        wr_strobe = 1'b0;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        m_dn[0] = !((7'h22 < m_mag[0]) && (3'd2 < m_lvl[0]));
        m_mag[0] = 7'h22; m_sign[0] = 1'b0;
        check_all("R3");
    endtask

    task automatic t_isolation();
        bus_write(1, 1, 8'h70, 1);          // ch1 threshold 7
        bus_write(1, 0, 8'h60, 1);          // ch1 96
        bus_write(0, 0, 8'h05, 1);          // ch0 falls, thr 0 -> high
        check_all("R11");
        bus_write(1, 0, 8'h10, 1);          // ch1 16<96, 1<7 -> low
        chk("R11", int'(decay_n[1]), 0);
        chk("R11", int'(decay_n[0]), 1);
        check_all("R11");
    endtask

    task automatic t_reset_again();
        do_reset();
        check_all("R1");
        bus_write(1, 0, 8'h00, 1);          // equal to 0 after reset -> high
        check_all("R1");
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mag_sign();
        t_decay();
        t_level_no_effect();
        t_cs_high();
        t_held_strobe();
        t_isolation();
        t_reset_again();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule